// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single down-counting timer channel driven through a byte-wide register interface. A control write picks how the 16-bit reload value is accessed and how the channel counts. Data writes assemble the reload value, and data reads return the live count, or a frozen snapshot of it, one byte at a time. Counting advances on a `tick` strobe, which is a one-clock pulse produced from the slower timer input clock. The channel drives an output pin and a one-clock interrupt pulse.

Three operating modes are supported: interrupt on terminal count, rate generator and square wave. Any other mode code is refused with an error pulse. Every access also carries a size in bytes, and only single-byte accesses are acted on. Decoding of several channels and gate behaviour are left to the surrounding logic.

Top module: `pit_channel`

## Requirements
- R1: After reset `out_pin`, `irq`, `err` and `rd_data` are 0, no snapshot is held, the next read returns the low byte, the channel is idle (ticks do nothing), the counter and reload are 0, the access mode is low-then-high and the operating mode is interrupt on terminal count.
- R2: A completed reload write makes the load pending. The next tick copies the reload into the counter without decrementing it, and the counter then runs. In non-square modes each later tick subtracts one.
- R3: Access codes on `ctl_acc` are 0 snapshot, 1 low byte only, 2 high byte only and 3 low then high. With code 3, the first data write sets bits 7:0, the second sets bits 15:8, and only the second completes the update. Code 1 makes every write a completed low-byte update. Code 2 makes every write a completed high-byte update.
- R4: In rate-generator mode, a reload completed while the channel is running leaves it running, and the new value is used from the next terminal count on. In every other case a completed reload makes the load pending.
- R5: Operating codes on `ctl_op` are 0 interrupt on terminal count, 2 rate generator and 3 square wave. In square-wave mode bit 0 of the reload is cleared when it is loaded, and each tick subtracts two.
- R6: At terminal count (the tick that would take the counter to 0) the counter reloads at once, so each period is exactly the loaded value in ticks. A loaded value of 0 stands for 65536.
- R7: In modes 0 and 2, `irq` is high for one clock, in the clock after each terminal-count tick. In square-wave mode `out_pin` toggles at each terminal count, and `irq` pulses only when that toggle takes `out_pin` from 0 to 1.
- R8: A snapshot command copies the live counter only when no snapshot is held. A repeated command before the high byte has been read changes nothing.
- R9: Reads alternate low byte then high byte and return the held snapshot if there is one, otherwise the live counter. Reading the high byte releases the snapshot. `rd_data` holds its value until the next accepted read.
- R10: A control write with a valid operating code stores the access and operating modes, sets `out_pin` to 1 and stops the channel until a new reload completes. Code 2 directs the next write to the high byte; the other codes direct it to the low byte. An operating code other than 0, 2 or 3 pulses `err` and changes nothing.
- R11: An access on any port whose `acc_size` is not 1 pulses `err` one clock later and changes no state. For a read, `rd_data` and the byte toggle are both left unchanged.
- R12: Within one clock, the tick is applied first, then the data write, then the control write. A read is served before a snapshot command in the same clock, so a high-byte read and a new snapshot may both happen in that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_size | input | SIZE_W | Size in bytes of the access in this clock |
| ctl_wr | input | 1 | Control write strobe |
| ctl_acc | input | 2 | Access code for the control write |
| ctl_op | input | 3 | Operating code for the control write |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | BYTE_W | Data write byte |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | BYTE_W | Byte returned by the last accepted read |
| tick | input | 1 | One-clock pulse per timer input period |
| out_pin | output | 1 | Channel output |
| irq | output | 1 | One-clock interrupt pulse |
| err | output | 1 | One-clock error pulse for a refused access |

## Verification
The bench builds the channel with its default parameters: 8-bit bytes, a 16-bit counter and a 3-bit access size. With a 16-bit counter, a reload of 0 gives a full 65536-tick period, and one directed run covers that whole period. The 3-bit size field lets random stimulus send refused sizes 0 and 2 to 7 on every port. Small random reload values make terminal counts, square-wave toggles and snapshot/readback collisions occur often within a few thousand cycles.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } acc_e;

    localparam logic [2:0] OP_TC   = 3'd0;
    localparam logic [2:0] OP_RATE = 3'd2;
    localparam logic [2:0] OP_SQ   = 3'd3;

    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_PEND = 2'd1,
        RUN_GO   = 2'd2
    } run_e;

    typedef enum logic {
        WAIT_LO = 1'b0,
        WAIT_HI = 1'b1
    } wait_e;

    function automatic logic op_valid(input logic [2:0] op);
        return (op == OP_TC) || (op == OP_RATE) || (op == OP_SQ);
    endfunction

endpackage

// File: rtl/pit_count_core.sv
`timescale 1ns/1ps
module pit_count_core
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [2*BYTE_W-1:0]   reload_i,
    input  logic [2:0]            op_i,
    input  logic                  reload_done_i,
    input  logic                  mode_set_i,
    output logic [2*BYTE_W-1:0]   cnt_o,
    output run_e                  run_o,
    output logic                  out_o,
    output logic                  irq_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        run_e             run;
        logic             out;
        logic             irq;
    } core_t;

    core_t c_d, c_q;

    logic             sq;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] step;
    logic [CNT_W:0]   cnt_ext;

    // In square-wave mode the load is forced even and the count drops by two.
    assign sq       = (op_i == OP_SQ);
    assign load_val = sq ? {reload_i[CNT_W-1:1], 1'b0} : reload_i;
    assign step     = sq ? CNT_W'(2) : CNT_W'(1);
    // A counter of zero stands for the full range 2**CNT_W.
    assign cnt_ext  = {c_q.cnt == '0, c_q.cnt};

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        // Tick first.
        if (tick) begin
            unique case (c_q.run)
                RUN_PEND: begin
                    c_d.cnt = load_val;
                    c_d.run = RUN_GO;
                end
                RUN_GO: begin
                    if (cnt_ext > {1'b0, step}) begin
                        c_d.cnt = c_q.cnt - step;
                    end else begin
                        // Terminal count: the next period starts with no dead tick.
                        c_d.cnt = load_val;
                        if (sq) begin
                            c_d.out = ~c_q.out;
                            c_d.irq = ~c_q.out;
                        end else begin
                            c_d.irq = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        // Then a completed reload.
        if (reload_done_i && !((op_i == OP_RATE) && (c_q.run == RUN_GO))) begin
            c_d.run = RUN_PEND;
        end
        // Then mode programming.
        if (mode_set_i) begin
            c_d.run = RUN_IDLE;
            c_d.out = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.cnt <= '0;
            c_q.run <= RUN_IDLE;
            c_q.out <= 1'b0;
            c_q.irq <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o = c_q.cnt;
    assign run_o = c_q.run;
    assign out_o = c_q.out;
    assign irq_o = c_q.irq;

endmodule

// File: rtl/pit_host_if.sv
`timescale 1ns/1ps
module pit_host_if
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SIZE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SIZE_W-1:0]     acc_size,
    input  logic                  ctl_wr,
    input  logic [1:0]            ctl_acc,
    input  logic [2:0]            ctl_op,
    input  logic                  wr_en,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [2*BYTE_W-1:0]   cnt_i,
    output logic [BYTE_W-1:0]     rd_data_o,
    output logic                  err_o,
    output logic [2*BYTE_W-1:0]   reload_o,
    output logic [2:0]            op_o,
    output logic                  reload_done_o,
    output logic                  mode_set_o,
    output logic                  held_o,
    output logic [2*BYTE_W-1:0]   latch_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  latch;
        logic              held;
        logic              rd_hi;
        wait_e             wr_wait;
        acc_e              acc;
        logic [2:0]        op;
        logic [BYTE_W-1:0] rd_data;
        logic              err;
    } hst_t;

    hst_t h_d, h_q;

    logic             size_ok;
    logic             done_d;
    logic             mset_d;
    logic [CNT_W-1:0] src;

    assign size_ok = (acc_size == SIZE_W'(1));
    assign src     = h_q.held ? h_q.latch : cnt_i;

    always_comb begin
        h_d     = h_q;
        h_d.err = 1'b0;
        done_d  = 1'b0;
        mset_d  = 1'b0;

        // Read, served before any snapshot command of the same clock.
        if (rd_en) begin
            if (!size_ok) begin
                h_d.err = 1'b1;
            end else if (!h_q.rd_hi) begin
                h_d.rd_data = src[BYTE_W-1:0];
                h_d.rd_hi   = 1'b1;
            end else begin
                h_d.rd_data = src[CNT_W-1:BYTE_W];
                h_d.rd_hi   = 1'b0;
                h_d.held    = 1'b0;
            end
        end

        // Reload byte assembly.
        if (wr_en) begin
            if (!size_ok) begin
                h_d.err = 1'b1;
            end else if (h_q.wr_wait == WAIT_LO) begin
                h_d.reload[BYTE_W-1:0] = wr_data;
                if (h_q.acc == ACC_LOHI) begin
                    h_d.wr_wait = WAIT_HI;
                end else begin
                    done_d = 1'b1;
                end
            end else begin
                h_d.reload[CNT_W-1:BYTE_W] = wr_data;
                if (h_q.acc == ACC_LOHI) begin
                    h_d.wr_wait = WAIT_LO;
                end
                done_d = 1'b1;
            end
        end

        // Control: snapshot or mode programming.
        if (ctl_wr) begin
            if (!size_ok) begin
                h_d.err = 1'b1;
            end else if (ctl_acc == ACC_LATCH) begin
                if (!h_d.held) begin
                    h_d.latch = cnt_i;
                    h_d.held  = 1'b1;
                end
            end else if (!op_valid(ctl_op)) begin
                h_d.err = 1'b1;
            end else begin
                h_d.acc     = acc_e'(ctl_acc);
                h_d.op      = ctl_op;
                h_d.wr_wait = (ctl_acc == ACC_HI) ? WAIT_HI : WAIT_LO;
                mset_d      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q.reload  <= '0;
            h_q.latch   <= '0;
            h_q.held    <= 1'b0;
            h_q.rd_hi   <= 1'b0;
            h_q.wr_wait <= WAIT_LO;
            h_q.acc     <= ACC_LOHI;
            h_q.op      <= OP_TC;
            h_q.rd_data <= '0;
            h_q.err     <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

    assign rd_data_o     = h_q.rd_data;
    assign err_o         = h_q.err;
    assign reload_o      = h_q.reload;
    assign op_o          = h_q.op;
    assign reload_done_o = done_d;
    assign mode_set_o    = mset_d;
    assign held_o        = h_q.held;
    assign latch_o       = h_q.latch;

endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_acc,
    input  logic [2:0]        ctl_op,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              tick,
    output logic              out_pin,
    output logic              irq,
    output logic              err
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] latch_w;
    logic [2:0]       op_w;
    logic             done_w;
    logic             mset_w;
    logic             held_w;
    run_e             run_w;

    pit_host_if #(
        .BYTE_W (BYTE_W),
        .SIZE_W (SIZE_W)
    ) i_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_size      (acc_size),
        .ctl_wr        (ctl_wr),
        .ctl_acc       (ctl_acc),
        .ctl_op        (ctl_op),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_en         (rd_en),
        .cnt_i         (cnt_w),
        .rd_data_o     (rd_data),
        .err_o         (err),
        .reload_o      (reload_w),
        .op_o          (op_w),
        .reload_done_o (done_w),
        .mode_set_o    (mset_w),
        .held_o        (held_w),
        .latch_o       (latch_w)
    );

    pit_count_core #(
        .BYTE_W (BYTE_W)
    ) i_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .reload_i      (reload_w),
        .op_i          (op_w),
        .reload_done_i (done_w),
        .mode_set_i    (mset_w),
        .cnt_o         (cnt_w),
        .run_o         (run_w),
        .out_o         (out_pin),
        .irq_o         (irq)
    );

endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              ctl_wr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BYTE_W-1:0] rd_data,
    input logic              out_pin,
    input logic              irq,
    input logic              err,
    input logic [2:0]        op_cur,
    input run_e              run_cur,
    input logic              cnt_lsb,
    input logic              held_cur,
    input logic [2*BYTE_W-1:0] latch_cur
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R7
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        irq |-> $past(tick));

    // R11
    err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        err |-> $past(ctl_wr || wr_en || rd_en));

    // R7
    sq_irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (irq && ($past(op_cur) == OP_SQ)) |-> (out_pin && !$past(out_pin)));

    // R5
    sq_even_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cur == RUN_GO) && (op_cur == OP_SQ)) |-> !cnt_lsb);

    // R8
    snapshot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (held_cur && $past(held_cur) && !$past(rd_en)) |-> $stable(latch_cur));

    // R9
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$past(rd_en) |-> $stable(rd_data));

endmodule

bind pit_channel pit_channel_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ctl_wr    (ctl_wr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .out_pin   (out_pin),
    .irq       (irq),
    .err       (err),
    .op_cur    (op_w),
    .run_cur   (run_w),
    .cnt_lsb   (cnt_w[0]),
    .held_cur  (held_w),
    .latch_cur (latch_w)
);

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;

    localparam int BYTE_W = 8;
    localparam int SIZE_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SIZE_W-1:0] acc_size = 3'd1;
    logic              ctl_wr = 1'b0;
    logic [1:0]        ctl_acc = 2'd0;
    logic [2:0]        ctl_op = 3'd0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = 8'd0;
    logic              rd_en = 1'b0;
    logic [7:0]        rd_data;
    logic              tick = 1'b0;
    logic              out_pin, irq, err;

    always #2 clk = ~clk;

    pit_channel #(.BYTE_W(BYTE_W), .SIZE_W(SIZE_W)) i_pit_channel (
        .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .ctl_wr(ctl_wr),
        .ctl_acc(ctl_acc), .ctl_op(ctl_op), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tick(tick), .out_pin(out_pin),
        .irq(irq), .err(err)
    );

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit finished = 0;

    // Reference model state, reset values per R1.
    logic [15:0] m_reload = 16'd0, m_latch = 16'd0, m_cnt = 16'd0;
    logic        m_held = 0, m_rdhi = 0, m_wait_hi = 0;
    logic [1:0]  m_acc = 2'd3;
    logic [2:0]  m_op = 3'd0;
    logic [1:0]  m_run = 2'd0;   // 0 idle, 1 pending, 2 running
    logic        m_out = 0, m_irq = 0, m_err = 0;
    logic [7:0]  m_rd = 8'd0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic valid_op(input logic [2:0] op);
        return (op == 3'd0) || (op == 3'd2) || (op == 3'd3);
    endfunction

    // Next state from the requirements, order per R12.
    task automatic model_step();
        logic [15:0] o_cnt = m_cnt, o_reload = m_reload, o_latch = m_latch;
        logic [1:0]  o_run = m_run, o_acc = m_acc;
        logic [2:0]  o_op = m_op;
        logic        o_out = m_out, o_held = m_held, o_rdhi = m_rdhi, o_wait = m_wait_hi;
        logic        ok = (acc_size == 3'd1);
        logic        done = 0, mset = 0;
        logic        sq = (o_op == 3'd3);
        logic [15:0] src = o_held ? o_latch : o_cnt;
        logic [15:0] ld = sq ? {o_reload[15:1], 1'b0} : o_reload;
        logic [16:0] ext = {o_cnt == 16'd0, o_cnt};
        logic [16:0] stp = sq ? 17'd2 : 17'd1;
        m_irq = 0;
        m_err = 0;
        if (rd_en) begin
            if (!ok) m_err = 1;
            else if (!o_rdhi) begin m_rd = src[7:0]; m_rdhi = 1; end
            else begin m_rd = src[15:8]; m_rdhi = 0; m_held = 0; end
        end
        if (wr_en) begin
            if (!ok) m_err = 1;
            else if (!o_wait) begin
                m_reload[7:0] = wr_data;
                if (o_acc == 2'd3) m_wait_hi = 1; else done = 1;
            end else begin
                m_reload[15:8] = wr_data;
                if (o_acc == 2'd3) m_wait_hi = 0;
                done = 1;
            end
        end
        if (ctl_wr) begin
            if (!ok) m_err = 1;
            else if (ctl_acc == 2'd0) begin
                if (!m_held) begin m_latch = o_cnt; m_held = 1; end
            end else if (!valid_op(ctl_op)) m_err = 1;
            else begin
                m_acc = ctl_acc; m_op = ctl_op; m_wait_hi = (ctl_acc == 2'd2); mset = 1;
            end
        end
        if (tick) begin
            if (o_run == 2'd1) begin m_cnt = ld; m_run = 2'd2; end
            else if (o_run == 2'd2) begin
                if (ext > stp) m_cnt = o_cnt - stp[15:0];
                else begin
                    m_cnt = ld;
                    if (sq) begin m_out = ~o_out; m_irq = ~o_out; end
                    else m_irq = 1;
                end
            end
        end
        if (done && !(o_op == 3'd2 && o_run == 2'd2)) m_run = 2'd1;
        if (mset) begin m_run = 2'd0; m_out = 1; end
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        #1;
        chk(out_pin, m_out, "R7 out_pin");
        chk(irq, m_irq, "R7 irq");
        chk(err, m_err, "R11 err");
        chk(rd_data, m_rd, "R9 rd_data");
        if (irq) irq_seen++;
        @(negedge clk);
        ctl_wr = 0; wr_en = 0; rd_en = 0; tick = 0; acc_size = 3'd1;
    endtask

    task automatic t_ctl(input logic [1:0] a, input logic [2:0] o);
        ctl_wr = 1; ctl_acc = a; ctl_op = o; cyc();
    endtask
    task automatic t_wr(input logic [7:0] d);
        wr_en = 1; wr_data = d; cyc();
    endtask
    task automatic t_rd();
        rd_en = 1; cyc();
    endtask
    task automatic t_tick(input int n);
        for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
    endtask

    initial begin
        #700000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(out_pin, 0, "R1 out_pin"); chk(irq, 0, "R1 irq");
        chk(err, 0, "R1 err"); chk(rd_data, 0, "R1 rd_data");
        t_tick(3);
        chk(irq, 0, "R1 idle no irq");
        t_rd(); chk(rd_data, 8'h00, "R1 counter zero");
        t_rd();

        // Rate generator, reload 5
        t_ctl(2'd3, 3'd2); chk(out_pin, 1, "R10 out high");
        t_wr(8'h05); t_wr(8'h00);
        t_tick(1);
        t_rd(); chk(rd_data, 8'h05, "R2 load without decrement");
        t_rd(); chk(rd_data, 8'h00, "R9 high byte");
        t_tick(4);
        t_tick(1); chk(irq, 1, "R6 terminal count irq");
        t_rd(); chk(rd_data, 8'h05, "R6 reloaded");
        t_rd();

        // R4: running rate generator, new reload not pending
        t_wr(8'h03); t_wr(8'h00);
        t_tick(1);
        t_rd(); chk(rd_data, 8'h04, "R4 still running");
        t_rd();
        t_tick(3);
        t_tick(1); chk(irq, 1, "R4 irq at old period");
        t_rd(); chk(rd_data, 8'h03, "R4 new reload at terminal count");
        t_rd();

        // Square wave, low byte only, reload 7 -> 6
        t_ctl(2'd1, 3'd3);
        t_wr(8'h07);
        t_tick(1);
        t_rd(); chk(rd_data, 8'h06, "R5 even load");
        t_rd();
        t_tick(1);
        t_rd(); chk(rd_data, 8'h04, "R5 step of two");
        t_rd();
        t_tick(2); chk(out_pin, 0, "R7 toggle low"); chk(irq, 0, "R7 no irq on fall");
        t_tick(2);
        t_tick(1); chk(out_pin, 1, "R7 toggle high"); chk(irq, 1, "R7 irq on rise");

        // R8 snapshot once
        t_ctl(2'd0, 3'd0);
        t_tick(1);
        t_ctl(2'd0, 3'd0);
        t_rd(); chk(rd_data, 8'h06, "R8 snapshot kept");
        t_tick(1);
        t_rd(); chk(rd_data, 8'h00, "R8 snapshot high");
        t_rd(); chk(rd_data, 8'h02, "R9 live after release");
        t_rd();

        // R3 high byte only
        t_ctl(2'd2, 3'd0);
        t_wr(8'h01);
        t_tick(1);
        t_rd(); chk(rd_data, 8'h07, "R3 low byte kept");
        t_rd(); chk(rd_data, 8'h01, "R3 high byte written");

        // R10 bad operating code
        t_ctl(2'd3, 3'd4); chk(err, 1, "R10 strobe refused");
        t_rd(); chk(rd_data, 8'h07, "R10 no change");
        t_rd();

        // R11 bad sizes
        acc_size = 3'd2; t_wr(8'hAA); chk(err, 1, "R11 write size");
        acc_size = 3'd0; t_ctl(2'd3, 3'd2); chk(err, 1, "R11 control size");
        acc_size = 3'd2; t_rd(); chk(rd_data, 8'h01, "R11 read ignored");
        t_tick(1);
        t_rd(); chk(rd_data, 8'h06, "R11 channel untouched");
        t_rd();

        // R12 read then snapshot in one clock
        t_ctl(2'd0, 3'd0);
        t_tick(1);
        t_rd(); chk(rd_data, 8'h06, "R12 snapshot low");
        rd_en = 1; ctl_wr = 1; ctl_acc = 2'd0; cyc();
        chk(rd_data, 8'h01, "R12 high released");
        t_rd(); chk(rd_data, 8'h05, "R12 new snapshot");
        t_rd();

        // R6 full range
        t_ctl(2'd3, 3'd2);
        t_wr(8'h00); t_wr(8'h00);
        irq_seen = 0;
        t_tick(65536);
        chk(irq_seen, 0, "R6 no early terminal count");
        t_tick(1);
        chk(irq, 1, "R6 zero means 65536");
        chk(irq_seen, 1, "R6 single irq");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 15) == 0) begin
                ctl_wr = 1;
                ctl_acc = 2'($urandom_range(0, 3));
                case ($urandom_range(0, 7))
                    0, 1: ctl_op = 3'd0;
                    2, 3: ctl_op = 3'd2;
                    4, 5: ctl_op = 3'd3;
                    default: ctl_op = 3'($urandom_range(0, 7));
                endcase
            end
            if ($urandom_range(0, 5) == 0) begin
                wr_en = 1;
                wr_data = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                                      : 8'($urandom_range(0, 9));
            end
            rd_en = ($urandom_range(0, 4) == 0);
            tick = $urandom_range(0, 1);
            if ($urandom_range(0, 31) == 0) acc_size = 3'($urandom_range(0, 7));
            cyc();
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule